// File: doc/BRIEF.md
# Serial Transceiver with DMA Request Handshake

This block is an asynchronous serial transmitter and receiver whose data registers are serviced by an external DMA engine rather than by a processor. Each direction has a single data register and a status flag. The transmit-empty flag and the receive-not-empty flag drive level request outputs toward the DMA engine. The engine answers a request by writing the transmit register or by reading the receive register. That access clears the flag, and the request falls on the following cycle. Each direction also has a done input. While the engine holds it high, the block stops requesting, even if its flag is set.

Frames are fixed at 8N1: one low start bit, eight data bits least significant bit first, and one high stop bit. Every bit lasts `baud_div` clock cycles. When the transmitter is switched on, it first holds the line high for a whole frame time before it sends any data. A transmission-complete flag reports that the last frame has left the line. Only an explicit clear input resets it. The receiver starts on a falling edge and checks the start bit again at mid-bit. It samples each data bit and the stop bit at mid-bit. It keeps the unread byte and flags an overrun if a newer byte arrives before the old one is read.

Top module: `uart_dma_link`

## Requirements
- R1: After `tx_en` rises, `txd` stays high for 10 bit periods (10 × `baud_div` cycles) before the first start bit. `txd` is high whenever the transmitter is disabled.
- R2: Each transmitted frame is a 0 start bit, 8 data bits least significant first, and a 1 stop bit, each bit `baud_div` cycles long.
- R3: `txe` is 1 after reset. A `tx_wr` pulse while `txe`=1 captures `tx_wdata` and clears `txe` on the next cycle. A `tx_wr` while `txe`=0 is ignored and the held byte is not replaced. `txe` returns to 1 once the shifter takes the byte.
- R4: `tx_dma_req` is 1 when `tx_dma_en`, `tx_en` and `txe` are 1 and `tx_dma_done` is 0. It is 0 in the cycle after the write that answers it.
- R5: `tc` is 0 after reset. It becomes 1 at the end of a frame's stop bit only if no byte is waiting in the transmit register. It stays 0 between back-to-back frames.
- R6: Only a `tc_clr` pulse clears `tc`. A transmit register write does not clear it.
- R7: While `tx_dma_done` or `rx_dma_done` is 1, the matching request output is 0 even though `txe` or `rxne` is 1.
- R8: A frame with a valid stop bit places its byte on `rx_rdata` and sets `rxne`. With `rx_dma_en`=1 and `rx_dma_done`=0, it also raises `rx_dma_req`.
- R9: An `rx_rd` pulse while `rxne`=1 clears `rxne`, and with it `rx_dma_req`, on the next cycle.
- R10: A frame that completes while `rxne`=1 sets `ovr` and is discarded, so `rx_rdata` keeps the unread byte. `ovr_clr` clears `ovr`.
- R11: A low pulse on `rxd` shorter than half a bit does not start a reception.
- R12: A frame whose stop bit is sampled as 0 is discarded and `rxne` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clock cycles per bit, at least 4 |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_dma_en | input | 1 | Transmit request enable |
| rx_dma_en | input | 1 | Receive request enable |
| tx_dma_done | input | 1 | DMA transmit count reached |
| rx_dma_done | input | 1 | DMA receive count reached |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_wdata | input | DATA_W | Transmit register write data |
| rx_rd | input | 1 | Receive register read strobe |
| tc_clr | input | 1 | Clear transmission-complete |
| ovr_clr | input | 1 | Clear overrun |
| rx_rdata | output | DATA_W | Receive register contents |
| txe | output | 1 | Transmit register empty |
| tc | output | 1 | Transmission complete |
| rxne | output | 1 | Receive register not empty |
| ovr | output | 1 | Receive overrun |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The bench builds the block with its default widths (8 data bits, 16-bit divisor) and drives `baud_div` at 8. With that divisor a frame lasts 80 cycles and half a bit lasts 4 cycles. The preamble window, back-to-back transmit frames fed by a modelled DMA engine, and a 2-cycle glitch below the half-bit threshold can then all be exercised in a few thousand cycles. The same short frames give room for a table of receive vectors, one of them with a bad stop bit, and for overrun and done-suppression cases.

// File: rtl/udl_pkg.sv
package udl_pkg;
  typedef enum logic [1:0] {TX_OFF, TX_PRE, TX_IDLE, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/udl_tx_buf.sv
module udl_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  input  logic              tx_en,
  input  logic              dma_en,
  input  logic              dma_done,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_v,
  output logic              txe,
  output logic              dma_req
);
  logic hold_v_d;
  logic load_en;

  always_comb begin
    load_en  = wr && !hold_v;
    hold_v_d = hold_v;
    if (take)         hold_v_d = 1'b0;
    else if (load_en) hold_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v <= 1'b0;
    else        hold_v <= hold_v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_data <= '0;
    else if (load_en) hold_data <= wdata;
  end

  assign txe     = !hold_v;
  assign dma_req = dma_en && tx_en && !hold_v && !dma_done;

  // R3: an accepted write empties the flag on the next cycle
  a_r3_write_clears_txe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && txe && !take) |=> !txe);
  // R3: a write into a full register changes nothing
  a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !txe) |=> $stable(hold_data));
  // R4: the request falls right after the answering write
  a_r4_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dma_req) |=> !dma_req);
endmodule

// File: rtl/udl_tx_shift.sv
module udl_tx_shift
  import udl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  div,
  input  logic              hold_v,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              tc_clr,
  output logic              take,
  output logic              txd,
  output logic              tc
);
  localparam int FB = DATA_W + 2;
  localparam int BW = $clog2(FB);
  localparam logic [BW-1:0] LAST_BIT = BW'(FB - 1);

  tx_state_e        st, st_d;
  logic [DIV_W-1:0] cnt, cnt_d, reload;
  logic [BW-1:0]    bitn, bit_d;
  logic [FB-1:0]    sh, sh_d;
  logic             tc_d, frame_done, tick;

  always_comb begin
    reload     = div - DIV_W'(1);
    tick       = (cnt == '0);
    st_d       = st;
    cnt_d      = cnt;
    bit_d      = bitn;
    sh_d       = sh;
    take       = 1'b0;
    frame_done = 1'b0;
    if (!tx_en) begin
      st_d = TX_OFF;
    end else begin
      case (st)
        TX_OFF: begin
          st_d  = TX_PRE;
          cnt_d = reload;
          bit_d = '0;
        end
        TX_PRE: begin
          if (tick) begin
            cnt_d = reload;
            if (bitn == LAST_BIT) st_d = TX_IDLE;
            else                  bit_d = bitn + 1'b1;
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
        TX_IDLE: begin
          if (hold_v) begin
            take  = 1'b1;
            sh_d  = {1'b1, hold_data, 1'b0};
            st_d  = TX_SEND;
            cnt_d = reload;
            bit_d = '0;
          end
        end
        default: begin
          if (tick) begin
            cnt_d = reload;
            if (bitn == LAST_BIT) begin
              frame_done = 1'b1;
              if (hold_v) begin
                take  = 1'b1;
                sh_d  = {1'b1, hold_data, 1'b0};
                bit_d = '0;
              end else begin
                st_d = TX_IDLE;
              end
            end else begin
              sh_d  = {1'b1, sh[FB-1:1]};
              bit_d = bitn + 1'b1;
            end
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
      endcase
    end
    tc_d = tc;
    if (tc_clr)                     tc_d = 1'b0;
    else if (frame_done && !hold_v) tc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_OFF;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '1;
      tc   <= 1'b0;
    end else begin
      st   <= st_d;
      cnt  <= cnt_d;
      bitn <= bit_d;
      sh   <= sh_d;
      tc   <= tc_d;
    end
  end

  assign txd = (st == TX_SEND) ? sh[0] : 1'b1;

  // R6: the completion flag holds until an explicit clear
  a_r6_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !tc_clr) |=> tc);
  // R5: a frame ending with a byte waiting never raises completion
  a_r5_tc_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && hold_v && !tc) |=> !tc);
  // R1: the line is never driven low before the preamble has ended
  a_r1_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_PRE) |=> (st != TX_SEND));
endmodule

// File: rtl/udl_rx.sv
module udl_rx
  import udl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic [DIV_W-1:0]  div,
  input  logic              rxd,
  input  logic              rd,
  input  logic              ovr_clr,
  input  logic              dma_en,
  input  logic              dma_done,
  output logic [DATA_W-1:0] rdata,
  output logic              rxne,
  output logic              ovr,
  output logic              dma_req
);
  localparam int RBW = $clog2(DATA_W);
  localparam logic [RBW-1:0] LAST_BIT = RBW'(DATA_W - 1);

  rx_state_e         st, st_d;
  logic [DIV_W-1:0]  cnt, cnt_d, reload;
  logic [RBW-1:0]    bitn, bit_d;
  logic [DATA_W-1:0] sh, sh_d;
  logic              s1, s2, s3;
  logic              fall, tick, deliver, accept;
  logic              rxne_d, ovr_d;

  always_comb begin
    reload  = div - DIV_W'(1);
    tick    = (cnt == '0);
    fall    = s3 && !s2;
    st_d    = st;
    cnt_d   = cnt;
    bit_d   = bitn;
    sh_d    = sh;
    deliver = 1'b0;
    if (!rx_en) begin
      st_d = RX_IDLE;
    end else begin
      case (st)
        RX_IDLE: begin
          if (fall) begin
            st_d  = RX_START;
            cnt_d = (div >> 1) - DIV_W'(1);
          end
        end
        RX_START: begin
          if (tick) begin
            if (!s2) begin
              st_d  = RX_DATA;
              cnt_d = reload;
              bit_d = '0;
            end else begin
              st_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (tick) begin
            sh_d  = {s2, sh[DATA_W-1:1]};
            cnt_d = reload;
            if (bitn == LAST_BIT) st_d = RX_STOP;
            else                  bit_d = bitn + 1'b1;
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
        default: begin
          if (tick) begin
            deliver = s2;
            st_d    = RX_IDLE;
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
      endcase
    end
    accept = deliver && !rxne;
    rxne_d = rxne;
    if (accept)  rxne_d = 1'b1;
    else if (rd) rxne_d = 1'b0;
    ovr_d = ovr;
    if (ovr_clr)              ovr_d = 1'b0;
    else if (deliver && rxne) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      rxne <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      st   <= st_d;
      cnt  <= cnt_d;
      bitn <= bit_d;
      sh   <= sh_d;
      rxne <= rxne_d;
      ovr  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (accept) rdata <= sh;
  end

  assign dma_req = dma_en && rxne && !dma_done;

  // R9: a read of a full register empties it on the next cycle
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rxne) |=> !rxne);
  // R10: an unread byte is never overwritten
  a_r10_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (rxne && !rd) |=> $stable(rdata));
  // R8: the flag only rises at the end of a stop bit
  a_r8_rise_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> ($past(st) == RX_STOP));
endmodule

// File: rtl/uart_dma_link.sv
module uart_dma_link #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  input  logic              tx_dma_done,
  input  logic              rx_dma_done,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  input  logic              tc_clr,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              txe,
  output logic              tc,
  output logic              rxne,
  output logic              ovr,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              txd,
  input  logic              rxd
);
  logic [DATA_W-1:0] hold_data;
  logic              hold_v;
  logic              take;

  udl_tx_buf #(.DATA_W(DATA_W)) u_tx_buf (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata), .take(take),
    .tx_en(tx_en), .dma_en(tx_dma_en), .dma_done(tx_dma_done),
    .hold_data(hold_data), .hold_v(hold_v), .txe(txe), .dma_req(tx_dma_req)
  );

  udl_tx_shift #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div(baud_div),
    .hold_v(hold_v), .hold_data(hold_data), .tc_clr(tc_clr),
    .take(take), .txd(txd), .tc(tc)
  );

  udl_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .div(baud_div), .rxd(rxd),
    .rd(rx_rd), .ovr_clr(ovr_clr), .dma_en(rx_dma_en), .dma_done(rx_dma_done),
    .rdata(rx_rdata), .rxne(rxne), .ovr(ovr), .dma_req(rx_dma_req)
  );
endmodule

// File: tb/uart_dma_link_bench.sv
module uart_dma_link_bench;
  localparam int DIV = 8;

  logic       clk, rst_n;
  logic [15:0] baud_div;
  logic       tx_en, rx_en, tx_dma_en, rx_dma_en, tx_dma_done, rx_dma_done;
  logic       tx_wr, rx_rd, tc_clr, ovr_clr, rxd;
  logic [7:0] tx_wdata, rx_rdata;
  logic       txe, tc, rxne, ovr, tx_dma_req, rx_dma_req, txd;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // receive vectors: [9] byte expected, [8] stop bit driven, [7:0] data
  localparam logic [9:0] RXV [0:5] = '{
    {1'b1, 1'b1, 8'h55}, {1'b1, 1'b1, 8'hA3}, {1'b1, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'h3C}, {1'b1, 1'b1, 8'h81}};
  localparam logic [7:0] TXV [0:2] = '{8'hC5, 8'h1E, 8'h6B};

  uart_dma_link u_uart_dma_link (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_en(tx_en), .rx_en(rx_en),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en), .tx_dma_done(tx_dma_done),
    .rx_dma_done(rx_dma_done), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
    .tc_clr(tc_clr), .ovr_clr(ovr_clr), .rx_rdata(rx_rdata), .txe(txe), .tc(tc),
    .rxne(rxne), .ovr(ovr), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .txd(txd), .rxd(rxd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic pulse_tc_clr();
    @(negedge clk); tc_clr = 1'b1;
    @(negedge clk); tc_clr = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic stop);
    @(negedge clk); rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  // waits for a start bit, returns the byte at mid-stop with the stop level
  task automatic decode_tx(output logic [7:0] d, output logic stop_ok, output int t_start);
    do @(negedge clk); while (txd !== 1'b0);
    t_start = cyc;
    repeat (DIV / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      d[i] = txd;
    end
    repeat (DIV) @(negedge clk);
    stop_ok = txd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    logic       stp;
    int         t0, ts;
    rst_n = 1'b0; baud_div = 16'(DIV);
    tx_en = 0; rx_en = 0; tx_dma_en = 0; rx_dma_en = 0; tx_dma_done = 0; rx_dma_done = 0;
    tx_wr = 0; rx_rd = 0; tc_clr = 0; ovr_clr = 0; rxd = 1; tx_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txe == 1'b1, "R3 reset txe", int'(txe), 1);
    chk(tc == 1'b0, "R5 reset tc", int'(tc), 0);
    chk(rxne == 1'b0 && ovr == 1'b0, "R8 reset rx flags", int'({rxne, ovr}), 0);
    chk(tx_dma_req == 1'b0 && rx_dma_req == 1'b0, "R4 reset reqs", int'({tx_dma_req, rx_dma_req}), 0);
    chk(txd == 1'b1, "R1 line idle while disabled", int'(txd), 1);

    // ---- receive vector table (R8, R9, R12) ----
    rx_en = 1; rx_dma_en = 1;
    repeat (4) @(negedge clk);
    foreach (RXV[k]) begin
      send_rx(RXV[k][7:0], RXV[k][8]);
      if (RXV[k][9]) begin
        chk(rxne == 1'b1, "R8 rxne set", int'(rxne), 1);
        chk(rx_rdata == RXV[k][7:0], "R8 rx data", int'(rx_rdata), int'(RXV[k][7:0]));
        chk(rx_dma_req == 1'b1, "R8 rx request", int'(rx_dma_req), 1);
        pulse_rd();
        chk(rxne == 1'b0 && rx_dma_req == 1'b0, "R9 read clears", int'({rxne, rx_dma_req}), 0);
      end else begin
        chk(rxne == 1'b0, "R12 bad stop discarded", int'(rxne), 0);
      end
    end

    // ---- R11 glitch rejection ----
    @(negedge clk); rxd = 1'b0;
    repeat (DIV / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    chk(rxne == 1'b0, "R11 glitch ignored", int'(rxne), 0);
    send_rx(8'h96, 1'b1);
    chk(rxne == 1'b1 && rx_rdata == 8'h96, "R11 frame after glitch", int'(rx_rdata), 'h96);
    pulse_rd();

    // ---- R7 rx done suppression and R10 overrun ----
    rx_dma_done = 1;
    send_rx(8'h5A, 1'b1);
    chk(rxne == 1'b1 && rx_dma_req == 1'b0, "R7 rx req suppressed", int'({rxne, rx_dma_req}), 2);
    send_rx(8'hE7, 1'b1);
    chk(ovr == 1'b1, "R10 overrun flagged", int'(ovr), 1);
    chk(rx_rdata == 8'h5A, "R10 unread byte kept", int'(rx_rdata), 'h5A);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk(ovr == 1'b0, "R10 ovr_clr", int'(ovr), 0);
    pulse_rd();
    rx_dma_done = 0;

    // ---- transmit without DMA: R1, R2, R3, R5, R6 ----
    @(negedge clk); tx_en = 1; t0 = cyc;
    pulse_wr(8'h4D);
    chk(txe == 1'b0, "R3 write clears txe", int'(txe), 0);
    pulse_wr(8'hB2);
    chk(txe == 1'b0, "R3 still full", int'(txe), 0);
    decode_tx(got, stp, ts);
    chk((ts - t0) >= 10 * DIV && (ts - t0) <= 10 * DIV + 3, "R1 preamble length", ts - t0, 10 * DIV);
    chk(got == 8'h4D, "R3 full write ignored / R2 data", int'(got), 'h4D);
    chk(stp == 1'b1, "R2 stop bit", int'(stp), 1);
    chk(txe == 1'b1, "R3 txe after take", int'(txe), 1);
    repeat (DIV) @(negedge clk);
    chk(tc == 1'b1, "R5 tc after last frame", int'(tc), 1);
    pulse_wr(8'h37);
    chk(tc == 1'b1, "R6 write keeps tc", int'(tc), 1);
    pulse_tc_clr();
    chk(tc == 1'b0, "R6 tc_clr clears", int'(tc), 0);
    decode_tx(got, stp, ts);
    chk(got == 8'h37 && stp == 1'b1, "R2 second frame", int'(got), 'h37);
    repeat (DIV) @(negedge clk);
    pulse_tc_clr();

    // ---- transmit by DMA handshake: R4, R5, R7, R2 ----
    tx_dma_en = 1;
    fork
      begin
        for (int k = 0; k < 3; k++) begin
          do @(negedge clk); while (tx_dma_req !== 1'b1);
          tx_wr = 1'b1; tx_wdata = TXV[k];
          @(negedge clk); tx_wr = 1'b0;
          chk(tx_dma_req == 1'b0, "R4 req drops after write", int'(tx_dma_req), 0);
        end
        tx_dma_done = 1;
      end
      begin
        for (int k = 0; k < 3; k++) begin
          logic [7:0] g;
          logic       s;
          int         t;
          decode_tx(g, s, t);
          chk(g == TXV[k] && s == 1'b1, "R2 dma frame", int'(g), int'(TXV[k]));
          if (k == 0) begin
            repeat (DIV / 2 + 2) @(negedge clk);
            chk(tc == 1'b0, "R5 tc low between frames", int'(tc), 0);
          end
        end
      end
    join
    chk(txe == 1'b1 && tx_dma_req == 1'b0, "R7 tx req suppressed", int'({txe, tx_dma_req}), 2);
    repeat (DIV) @(negedge clk);
    chk(tc == 1'b1, "R5 tc after dma block", int'(tc), 1);
    tx_en = 0;
    @(negedge clk);
    chk(txd == 1'b1 && tx_dma_req == 1'b0, "R4 no req when disabled", int'({txd, tx_dma_req}), 2);

    finish_run();
  end
endmodule